// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the control and status register file of a processor core module. It sits on a simple 32-bit register bus with a 7-bit word index. Each access is one request cycle, and it gets exactly one response cycle later with read data and an error flag. The register file holds the following:

- constant identification and status words
- two clock-setting registers that accept writes only while a 16-bit unlock key is stored
- a control register
- two flag registers, each written through separate set and clear words
- an SDRAM configuration word whose reset value carries a memory-size code
- a read-only window onto a 128-byte presence table
- a small interrupt status group with IRQ and FIQ enable masks and one software interrupt bit

Two signals leave the block besides the bus response. The first is a one-cycle reset request, fired by a control write with bit 3 set. The second is the boot alias enable, which follows control bit 2. While that bit is 0, flash is aliased at address zero. When it is 1, the alias is removed so RAM appears there. The memory size, identification word and presence table contents are fixed at elaboration by parameters.

Top module: `cm_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows: word 2 = 0x01000048, word 7 = 0x0007FEFF, word 9 = 0x00000112, words 3, 5, 12 and 14 = 0, and the enable masks and the soft interrupt bit = 0.
- R2: Word 0 reads parameter ID_WORD (default 0x5A3E0001) and word 1 reads 0. Word 4 reads 0x00100000. Words 32 to 35 read 0, accept writes without error and ignore them.
- R3: A write to word 5 stores only data bits 15:0. While the stored value is 0xA05F, word 5 reads 0x0001A05F; otherwise it reads the stored value.
- R4: Writes to words 2 and 7 update them only while word 5 holds 0xA05F. Otherwise those writes are ignored and return no error.
- R5: A write to word 3 stores data bits 0 and 2 only, and bit 3 always reads 0. If the written bit 3 is 1, reset_req is high for exactly the one cycle after the request.
- R6: flash_alias_en is the inverse of control bit 2. It is 1 after reset.
- R7: Word 12 reads the flags, and a write to it ORs the data in. A write to word 13 clears the flag bits set in the data. Words 14 and 15 act the same way on a second flag register.
- R8: Words 64 to 95 read the presence-table byte whose index equals the word number, zero-extended. Words 96 to 127 read 0. With the default table, byte i = (37*i + 11) mod 256.
- R9: Word 17 reads the level, which is the soft bit in bit 0. Word 16 reads level AND IRQ mask. Word 18 reads the IRQ mask: a write to it sets mask bits and a write to word 19 clears them. Data bit 0 written to word 20 sets the soft bit, and written to word 21 clears it. Word 20 reads the soft bit. Words 24, 25, 26 and 27 do the same with the FIQ mask.
- R10: An undefined access returns rsp_err = 1 with data 0 and changes nothing. Undefined reads are words 6, 10, 11, 13, 15, 19, 21 to 23, 27 to 31 and 36 to 63. Undefined writes are words 0, 1, 4, 6, 10, 11, 16, 17, 22 to 25, 28 to 31 and 36 to 127.
- R11: Word 8 resets to 0x00011122 ORed with a size code taken from parameter MEM_MB: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, else 0. The default is 128, giving 0x0001112E. Words 8 and 9 take full 32-bit writes.
- R12: rsp_valid is high in exactly the cycle after each request cycle. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 7 | Word index of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Undefined access |
| reset_req | output | 1 | One-cycle system reset request |
| flash_alias_en | output | 1 | Flash aliased at address zero |

## Verification
The bench writes the clock registers with the key absent, present and then removed again. A design that gates on the written value instead of the stored key, or that keeps bits above 15 of the lock, would accept writes it should drop or read back the wrong lock word. The control writes check that bit 3 pulses reset_req for one cycle and never reads back, and that bit 0 alone does not move the alias. The interrupt and flag sequences mix set and clear words and write soft-set data with bit 0 at 0, which exposes a design that sets on any nonzero data. The table window is probed at both edges and in its upper zero half, and undefined reads and writes are followed by read-back to show that nothing changed.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

  localparam int DATA_W   = 32;
  localparam int WORD_AW  = 7;
  localparam int TBL_BYTES = 1 << WORD_AW;
  localparam int TBL_W    = TBL_BYTES * 8;
  localparam logic [15:0] LOCK_KEY = 16'hA05F;
  localparam logic [DATA_W-1:0] STATUS_WORD = 32'h0010_0000;
  localparam logic [DATA_W-1:0] SDRAM_BASE  = 32'h0001_1122;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_ID, SEL_ZERO, SEL_OSC, SEL_CTRL, SEL_STAT, SEL_LOCK,
    SEL_AUX, SEL_SDRAM, SEL_INIT, SEL_FLAGS, SEL_FLAGS_CLR, SEL_NV,
    SEL_NV_CLR, SEL_IRQ_STAT, SEL_IRQ_RAW, SEL_IRQ_EN, SEL_IRQ_ENCLR,
    SEL_SOFT, SEL_SOFT_CLR, SEL_FIQ_STAT, SEL_FIQ_RAW, SEL_FIQ_EN,
    SEL_FIQ_ENCLR, SEL_VOLT, SEL_TABLE, SEL_TABLE_HI
  } reg_sel_e;

  // index of each set/clear register in the shared bank
  localparam int SC_FLAGS = 0;
  localparam int SC_NV    = 1;
  localparam int SC_IRQ   = 2;
  localparam int SC_FIQ   = 3;
  localparam int SC_NUM   = 4;

  function automatic logic [TBL_W-1:0] default_table();
    logic [TBL_W-1:0] t;
    for (int i = 0; i < TBL_BYTES; i++) begin
      t[i*8 +: 8] = 8'((37 * i + 11) % 256);
    end
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] size_code(int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/cmr_decode.sv
module cmr_decode
  import cmr_pkg::*;
(
  input  logic [WORD_AW-1:0] word,
  output reg_sel_e           sel,
  output logic               rd_ok,
  output logic               wr_ok
);

  always_comb begin
    sel = SEL_NONE;
    if (word[WORD_AW-1]) begin
      sel = word[WORD_AW-2] ? SEL_TABLE_HI : SEL_TABLE;
    end else begin
      case (word)
        7'd0:  sel = SEL_ID;
        7'd1:  sel = SEL_ZERO;
        7'd2:  sel = SEL_OSC;
        7'd3:  sel = SEL_CTRL;
        7'd4:  sel = SEL_STAT;
        7'd5:  sel = SEL_LOCK;
        7'd7:  sel = SEL_AUX;
        7'd8:  sel = SEL_SDRAM;
        7'd9:  sel = SEL_INIT;
        7'd12: sel = SEL_FLAGS;
        7'd13: sel = SEL_FLAGS_CLR;
        7'd14: sel = SEL_NV;
        7'd15: sel = SEL_NV_CLR;
        7'd16: sel = SEL_IRQ_STAT;
        7'd17: sel = SEL_IRQ_RAW;
        7'd18: sel = SEL_IRQ_EN;
        7'd19: sel = SEL_IRQ_ENCLR;
        7'd20: sel = SEL_SOFT;
        7'd21: sel = SEL_SOFT_CLR;
        7'd24: sel = SEL_FIQ_STAT;
        7'd25: sel = SEL_FIQ_RAW;
        7'd26: sel = SEL_FIQ_EN;
        7'd27: sel = SEL_FIQ_ENCLR;
        7'd32, 7'd33, 7'd34, 7'd35: sel = SEL_VOLT;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ID, SEL_ZERO, SEL_OSC, SEL_CTRL, SEL_STAT, SEL_LOCK, SEL_AUX,
      SEL_SDRAM, SEL_INIT, SEL_FLAGS, SEL_NV, SEL_IRQ_STAT, SEL_IRQ_RAW,
      SEL_IRQ_EN, SEL_SOFT, SEL_FIQ_STAT, SEL_FIQ_RAW, SEL_FIQ_EN,
      SEL_VOLT, SEL_TABLE, SEL_TABLE_HI: rd_ok = 1'b1;
      default: rd_ok = 1'b0;
    endcase
    case (sel)
      SEL_OSC, SEL_CTRL, SEL_LOCK, SEL_AUX, SEL_SDRAM, SEL_INIT,
      SEL_FLAGS, SEL_FLAGS_CLR, SEL_NV, SEL_NV_CLR, SEL_IRQ_EN,
      SEL_IRQ_ENCLR, SEL_SOFT, SEL_SOFT_CLR, SEL_FIQ_EN, SEL_FIQ_ENCLR,
      SEL_VOLT: wr_ok = 1'b1;
      default: wr_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmr_setclr_reg.sv
module cmr_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (set_en)      q_next = q | wdata;
    else if (clr_en) q_next = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (set_en || clr_en) q <= q_next;
  end

endmodule

// File: rtl/cmr_keyed_osc.sv
module cmr_keyed_osc
  import cmr_pkg::*;
#(
  parameter logic [DATA_W-1:0] OSC_RST = 32'h0100_0048,
  parameter logic [DATA_W-1:0] AUX_RST = 32'h0007_FEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_we,
  input  logic              osc_we,
  input  logic              aux_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       lock_q,
  output logic              key_held,
  output logic [DATA_W-1:0] osc_q,
  output logic [DATA_W-1:0] aux_q
);

  logic osc_en, aux_en;

  assign key_held = (lock_q == LOCK_KEY);
  assign osc_en   = osc_we && key_held;
  assign aux_en   = aux_we && key_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (lock_we) lock_q <= wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      osc_q <= OSC_RST;
    else if (osc_en) osc_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux_q <= AUX_RST;
    else if (aux_en) aux_q <= wdata;
  end

endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs
  import cmr_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD    = 32'h5A3E_0001,
  parameter int                MEM_MB     = 128,
  parameter logic [TBL_W-1:0]  PRES_TABLE = default_table(),
  parameter logic [DATA_W-1:0] OSC_RST    = 32'h0100_0048,
  parameter logic [DATA_W-1:0] AUX_RST    = 32'h0007_FEFF,
  parameter logic [DATA_W-1:0] INIT_RST   = 32'h0000_0112
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [WORD_AW-1:0] req_word,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               reset_req,
  output logic               flash_alias_en
);

  localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0005;
  localparam int                CTRL_REMAP_BIT = 2;
  localparam int                CTRL_RESET_BIT = 3;

  reg_sel_e sel;
  logic     rd_ok, wr_ok;
  logic     do_wr, do_rd, bad;

  cmr_decode u_dec (
    .word (req_word),
    .sel  (sel),
    .rd_ok(rd_ok),
    .wr_ok(wr_ok)
  );

  assign do_wr = req_valid &&  req_write && wr_ok;
  assign do_rd = req_valid && !req_write && rd_ok;
  assign bad   = req_valid && (req_write ? !wr_ok : !rd_ok);

  // keyed clock registers
  logic [15:0]       lock_q;
  logic              key_held;
  logic [DATA_W-1:0] osc_q, aux_q;

  cmr_keyed_osc #(.OSC_RST(OSC_RST), .AUX_RST(AUX_RST)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_we (do_wr && sel == SEL_LOCK),
    .osc_we  (do_wr && sel == SEL_OSC),
    .aux_we  (do_wr && sel == SEL_AUX),
    .wdata   (req_wdata),
    .lock_q  (lock_q),
    .key_held(key_held),
    .osc_q   (osc_q),
    .aux_q   (aux_q)
  );

  // set/clear bank: flags, non-volatile flags, irq mask, fiq mask
  logic [SC_NUM-1:0] sc_set, sc_clr;
  logic [DATA_W-1:0] sc_q [SC_NUM];

  always_comb begin
    sc_set = '0;
    sc_clr = '0;
    sc_set[SC_FLAGS] = do_wr && sel == SEL_FLAGS;
    sc_clr[SC_FLAGS] = do_wr && sel == SEL_FLAGS_CLR;
    sc_set[SC_NV]    = do_wr && sel == SEL_NV;
    sc_clr[SC_NV]    = do_wr && sel == SEL_NV_CLR;
    sc_set[SC_IRQ]   = do_wr && sel == SEL_IRQ_EN;
    sc_clr[SC_IRQ]   = do_wr && sel == SEL_IRQ_ENCLR;
    sc_set[SC_FIQ]   = do_wr && sel == SEL_FIQ_EN;
    sc_clr[SC_FIQ]   = do_wr && sel == SEL_FIQ_ENCLR;
  end

  for (genvar g = 0; g < SC_NUM; g++) begin : g_sc
    cmr_setclr_reg #(.W(DATA_W)) u_sc (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(sc_set[g]),
      .clr_en(sc_clr[g]),
      .wdata (req_wdata),
      .q     (sc_q[g])
    );
  end

  // plain registers
  logic [DATA_W-1:0] ctrl_q, ctrl_next;
  logic [DATA_W-1:0] sdram_q, init_q;
  logic              soft_q, soft_next;
  logic              ctrl_en, sdram_en, init_en, soft_en;
  logic              rst_pulse_next;

  assign ctrl_en   = do_wr && sel == SEL_CTRL;
  assign sdram_en  = do_wr && sel == SEL_SDRAM;
  assign init_en   = do_wr && sel == SEL_INIT;
  assign ctrl_next = req_wdata & CTRL_MASK;
  assign rst_pulse_next = ctrl_en && req_wdata[CTRL_RESET_BIT];

  always_comb begin
    soft_en   = 1'b0;
    soft_next = soft_q;
    if (do_wr && sel == SEL_SOFT && req_wdata[0]) begin
      soft_en   = 1'b1;
      soft_next = 1'b1;
    end else if (do_wr && sel == SEL_SOFT_CLR && req_wdata[0]) begin
      soft_en   = 1'b1;
      soft_next = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdram_q <= SDRAM_RST;
    else if (sdram_en) sdram_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       init_q <= INIT_RST;
    else if (init_en) init_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       soft_q <= 1'b0;
    else if (soft_en) soft_q <= soft_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= rst_pulse_next;
  end

  assign flash_alias_en = !ctrl_q[CTRL_REMAP_BIT];

  // read path
  logic [DATA_W-1:0] level, rd_val, rdata_next;

  assign level = {{(DATA_W-1){1'b0}}, soft_q};

  always_comb begin
    case (sel)
      SEL_ID:       rd_val = ID_WORD;
      SEL_OSC:      rd_val = osc_q;
      SEL_CTRL:     rd_val = ctrl_q;
      SEL_STAT:     rd_val = STATUS_WORD;
      SEL_LOCK:     rd_val = {15'd0, key_held, lock_q};
      SEL_AUX:      rd_val = aux_q;
      SEL_SDRAM:    rd_val = sdram_q;
      SEL_INIT:     rd_val = init_q;
      SEL_FLAGS:    rd_val = sc_q[SC_FLAGS];
      SEL_NV:       rd_val = sc_q[SC_NV];
      SEL_IRQ_STAT: rd_val = level & sc_q[SC_IRQ];
      SEL_IRQ_RAW,
      SEL_FIQ_RAW:  rd_val = level;
      SEL_IRQ_EN:   rd_val = sc_q[SC_IRQ];
      SEL_SOFT:     rd_val = level;
      SEL_FIQ_STAT: rd_val = level & sc_q[SC_FIQ];
      SEL_FIQ_EN:   rd_val = sc_q[SC_FIQ];
      SEL_TABLE:    rd_val = {24'd0, PRES_TABLE[req_word*8 +: 8]};
      default:      rd_val = '0;
    endcase
  end

  assign rdata_next = do_rd ? rd_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= bad;
      rsp_rdata <= rdata_next;
    end
  end

endmodule

// File: rtl/cm_ctrl_regs_chk.sv
module cm_ctrl_regs_chk
  import cmr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [WORD_AW-1:0] req_word,
  input logic [DATA_W-1:0]  req_wdata,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               reset_req,
  input logic               flash_alias_en,
  input logic [DATA_W-1:0]  osc_q,
  input logic               key_held
);

  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(req_valid && req_write && req_word == 7'd3 && req_wdata[3]));

  a_r4_osc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osc_q) |-> $past(key_held && req_valid && req_write && req_word == 7'd2));

  a_r6_remap_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flash_alias_en) |-> $past(req_valid && req_write && req_word == 7'd3));

endmodule

bind cm_ctrl_regs cm_ctrl_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_word      (req_word),
  .req_wdata     (req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .reset_req     (reset_req),
  .flash_alias_en(flash_alias_en),
  .osc_q         (osc_q),
  .key_held      (key_held)
);

// File: tb/cm_ctrl_regs_bench.sv
module cm_ctrl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_word = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, reset_req, flash_alias_en;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
    logic [6:0]  word;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  cm_ctrl_regs u_cm_ctrl_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_word      (req_word),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_err       (rsp_err),
    .reset_req     (reset_req),
    .flash_alias_en(flash_alias_en)
  );

  function automatic logic [31:0] tbl_byte(int i);
    return 32'((37 * i + 11) % 256);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // driver: one request cycle, expected response pushed to the scoreboard
  task automatic acc(bit wr, int word, logic [31:0] wd, logic [31:0] ed, bit ee, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_word  = 7'(word);
    req_wdata = wd;
    e.data = wr ? 32'd0 : ed;
    e.err  = ee;
    e.tag  = tag;
    e.word = 7'(word);
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic rd(int word, logic [31:0] ed, string tag);
    acc(1'b0, word, 32'd0, ed, 1'b0, tag);
  endtask

  task automatic wr(int word, logic [31:0] wd, string tag);
    acc(1'b1, word, wd, 32'd0, 1'b0, tag);
  endtask

  // monitor: pops and compares each response (R12 timing included)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R12: actual unexpected response expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " data"}, rsp_rdata, e.data);
        check({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 alias after reset", {31'd0, flash_alias_en}, 32'd1);
    check("R5 no reset_req after reset", {31'd0, reset_req}, 32'd0);

    // reset state
    rd(2, 32'h0100_0048, "R1 osc");
    rd(7, 32'h0007_FEFF, "R1 aux");
    rd(9, 32'h0000_0112, "R1 init");
    rd(3, 32'h0, "R1 ctrl");
    rd(5, 32'h0, "R1 lock");
    rd(12, 32'h0, "R1 flags");
    rd(14, 32'h0, "R1 nvflags");
    rd(18, 32'h0, "R1 irq mask");
    rd(26, 32'h0, "R1 fiq mask");
    rd(8, 32'h0001_112E, "R11 sdram");
    rd(0, 32'h5A3E_0001, "R2 id");
    rd(1, 32'h0, "R2 zero");
    rd(4, 32'h0010_0000, "R2 status");

    // keyed clock registers
    wr(2, 32'hDEAD_BEEF, "R4 osc locked");
    rd(2, 32'h0100_0048, "R4 osc unchanged");
    wr(5, 32'h1234_A05F, "R3 unlock");
    rd(5, 32'h0001_A05F, "R3 key read");
    wr(2, 32'h1234_5678, "R4 osc unlocked");
    rd(2, 32'h1234_5678, "R4 osc written");
    wr(7, 32'hCAFE_0001, "R4 aux unlocked");
    rd(7, 32'hCAFE_0001, "R4 aux written");
    wr(5, 32'hFFFF_0001, "R3 relock");
    rd(5, 32'h0000_0001, "R3 plain read");
    wr(7, 32'h0, "R4 aux locked");
    rd(7, 32'hCAFE_0001, "R4 aux unchanged");

    // control, reset pulse, remap
    wr(3, 32'h0000_0001, "R5 ctrl bit0");
    check("R6 alias with bit0 only", {31'd0, flash_alias_en}, 32'd1);
    check("R5 no pulse without bit3", {31'd0, reset_req}, 32'd0);
    wr(3, 32'hFFFF_FFFF, "R5 ctrl all");
    check("R5 pulse high", {31'd0, reset_req}, 32'd1);
    check("R6 alias off", {31'd0, flash_alias_en}, 32'd0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, reset_req}, 32'd0);
    rd(3, 32'h0000_0005, "R5 ctrl readback");
    wr(3, 32'h0, "R6 ctrl clear");
    check("R6 alias back on", {31'd0, flash_alias_en}, 32'd1);

    // flags
    wr(12, 32'h0000_F0F0, "R7 flag set");
    wr(12, 32'h0001_0000, "R7 flag set more");
    wr(13, 32'h0000_3000, "R7 flag clr");
    rd(12, 32'h0001_C0F0, "R7 flags");
    wr(14, 32'hAAAA_0000, "R7 nv set");
    wr(15, 32'h8000_0000, "R7 nv clr");
    rd(14, 32'h2AAA_0000, "R7 nvflags");
    rd(12, 32'h0001_C0F0, "R7 flags separate");

    // interrupt group
    wr(20, 32'h1, "R9 soft set");
    rd(17, 32'h1, "R9 raw");
    rd(16, 32'h0, "R9 masked off");
    wr(18, 32'h3, "R9 irq en set");
    rd(18, 32'h3, "R9 irq mask");
    rd(16, 32'h1, "R9 irq status");
    rd(20, 32'h1, "R9 soft read");
    wr(19, 32'h1, "R9 irq en clr");
    rd(16, 32'h0, "R9 status after clr");
    rd(18, 32'h2, "R9 mask after clr");
    wr(26, 32'h5, "R9 fiq en set");
    rd(24, 32'h1, "R9 fiq status");
    rd(25, 32'h1, "R9 fiq raw");
    wr(27, 32'h4, "R9 fiq en clr");
    rd(26, 32'h1, "R9 fiq mask");
    wr(21, 32'hFFFF_FFFE, "R9 soft clr bit0 zero");
    rd(17, 32'h1, "R9 soft kept");
    wr(21, 32'h1, "R9 soft clr");
    rd(17, 32'h0, "R9 raw cleared");
    rd(24, 32'h0, "R9 fiq status cleared");
    wr(20, 32'hFFFF_FFFE, "R9 soft set bit0 zero");
    rd(20, 32'h0, "R9 soft still clear");

    // voltage words, sdram, init
    wr(33, 32'hFFFF_FFFF, "R2 volt write");
    rd(33, 32'h0, "R2 volt read");
    rd(35, 32'h0, "R2 volt read hi");
    wr(8, 32'h1357_9BDF, "R11 sdram write");
    rd(8, 32'h1357_9BDF, "R11 sdram read");
    wr(9, 32'h2468_ACE0, "R11 init write");
    rd(9, 32'h2468_ACE0, "R11 init read");

    // presence table window
    rd(64, tbl_byte(64), "R8 first byte");
    rd(80, tbl_byte(80), "R8 mid byte");
    rd(95, tbl_byte(95), "R8 last byte");
    rd(96, 32'h0, "R8 upper zero");
    rd(127, 32'h0, "R8 top zero");

    // undefined accesses
    acc(1'b0, 6, 32'h0, 32'h0, 1'b1, "R10 read word6");
    acc(1'b0, 13, 32'h0, 32'h0, 1'b1, "R10 read clr word");
    acc(1'b0, 40, 32'h0, 32'h0, 1'b1, "R10 read hole");
    acc(1'b1, 0, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10 write id");
    rd(0, 32'h5A3E_0001, "R10 id unchanged");
    acc(1'b1, 70, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10 write table");
    rd(70, tbl_byte(70), "R10 table unchanged");
    acc(1'b1, 17, 32'h1, 32'h0, 1'b1, "R10 write raw");
    rd(17, 32'h0, "R10 raw unchanged");

    // back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 7'd4;
    exp_q.push_back('{32'h0010_0000, 1'b0, "R12 burst a", 7'd4});
    @(negedge clk);
    req_word = 7'd1;
    exp_q.push_back('{32'h0, 1'b0, "R12 burst b", 7'd1});
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12: actual %0d responses missing expected 0", exp_q.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule